// File: doc/BRIEF.md
# Power-Sourcing Port Sequencing Controller

This block is the autonomous control state machine of one power-sourcing Ethernet port. It takes the port from idle through a signature detection phase and a classification phase, waits a fixed power-on delay, asks the shared power budget whether the port may be switched on, and then holds the port powered. While the port is powered it watches an overload comparator and a disconnect request. Detection and classification are measured by analog circuitry outside the block. The block only opens the measurement windows and reads the result codes at the end of each window.

Every duration is a count of a one-cycle `tick` strobe, and each length is a parameter. A midspan strap adds a backoff after a failed detection. A shutdown input forces the port off at once, and a restart wait follows release, overload or budget denial. An enforce-class strap lets the detected class choose the overload threshold code that is handed to the current-limit circuitry. A fault code records why the port last went off or stayed off.

Top module: `poe_port_seq`

## Requirements
- R1: After reset, or after a detection restart, `det_en` is high for exactly `T_DET` ticks. When the window ends, `det_res` is read with these codes: 2'b01 valid, 2'b10 open circuit, 2'b00 and 2'b11 invalid.
- R2: A valid result is followed at once by `cls_en` high for exactly `T_CLS` ticks. At the last tick, `cls_meas` is decoded and latched.
- R3: `port_en` rises exactly `T_PON` ticks after detection ends, provided the budget check passes. That is `T_CLS` ticks of classification followed by `T_PON - T_CLS` ticks of waiting.
- R4: `cls_meas` is in units of 0.5 mA. Values below `CLS_B1` (default 11) give class 0. Values from `CLS_B1` up to `CLS_B2-1` (default 27) give class 1. Values from `CLS_B2` up to `CLS_B3-1` (default 43) give class 2. Anything higher gives class 3, so class 4 and above read as 3. While the port is powered, `pm_code` is class+1. It is 0 when the port is off.
- R5: `ovld_thr` is latched when classification ends. The codes are 0 for the high threshold, 1 for the lowest and 2 for the middle. With `enforce_cls` high, class 1 gives 1, class 2 gives 2, and classes 0 and 3 give 0. With `enforce_cls` low, every class gives 0.
- R6: An invalid result with `midspan` high starts a backoff of exactly `T_BACKOFF` ticks before the next detection. An open result, or an invalid result with `midspan` low, restarts detection after one idle cycle with no wait.
- R7: If `ovld_flag` is high at `T_OVLD` consecutive ticks while powered, the port turns off with fault code 1. Any cycle with the flag low clears the count. Detection restarts after exactly `T_RESTART` ticks.
- R8: `budget_over` is read at the end of the power-on delay. If it is high, the port stays off, the fault code becomes 4, and detection restarts after `T_RESTART` ticks.
- R9: While `shutdown` is high, the port is off and no detection runs. Asserting it sets fault code 3 on the next clock edge. After release, detection starts after exactly `T_RESTART` ticks.
- R10: `disc_req` while powered turns the port off on the next edge with fault code 2. Detection then restarts after one idle cycle, with no wait.
- R11: A fault code stays unchanged until the next detection begins, and it clears to 0 at that point.
- R12: During and right after synchronous reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase strobe |
| det_res | input | 2 | Detection result code |
| cls_meas | input | MEAS_W | Classification current, 0.5 mA units |
| ovld_flag | input | 1 | Overload comparator output |
| disc_req | input | 1 | Disconnect request |
| shutdown | input | 1 | Forces the port off and halts sequencing |
| midspan | input | 1 | Enables backoff after invalid detection |
| enforce_cls | input | 1 | Lets the class choose the overload threshold |
| budget_over | input | 1 | Shared power budget exceeded |
| port_en | output | 1 | Port power switch enable |
| det_en | output | 1 | Detection phase enable |
| cls_en | output | 1 | Classification phase enable |
| ovld_thr | output | 2 | Overload threshold code |
| pm_code | output | 3 | Power-management current code |
| fault | output | 3 | Fault status code |

## Verification
The bench drops the overload flag for one cycle partway through the overload window. A design that does not clear the count would trip two ticks early. It then walks `cls_meas` across both sides of every class boundary, including a class-4 reading. A wrong comparison would show up as a shifted `pm_code` or threshold code. It separates open and invalid results with the strap set and clear, which catches a backoff applied to open circuits or a backoff that is missing. It releases shutdown at a known tick phase, so a restart wait that is off by one, or a detection that starts during shutdown, changes the counted tick total.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_DET, S_CLS, S_PWAIT, S_ON, S_FWAIT, S_BACKOFF, S_SHUT
    } seq_state_e;

    typedef enum logic [1:0] { PDC_0, PDC_1, PDC_2, PDC_3 } pd_class_e;

    typedef enum logic [1:0] {
        THR_HIGH = 2'd0,
        THR_LOW  = 2'd1,
        THR_MID  = 2'd2
    } ovld_thr_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_OVLD   = 3'd1,
        FLT_DISC   = 3'd2,
        FLT_SHUT   = 3'd3,
        FLT_BUDGET = 3'd4
    } fault_e;

    localparam logic [1:0] DET_VALID = 2'b01;
    localparam logic [1:0] DET_OPEN  = 2'b10;

    typedef struct packed {
        pd_class_e cls;
        ovld_thr_e thr;
    } pd_profile_t;

    function automatic ovld_thr_e pick_thr(pd_class_e c, logic enf);
        ovld_thr_e t;
        t = THR_HIGH;
        if (enf) begin
            case (c)
                PDC_1:   t = THR_LOW;
                PDC_2:   t = THR_MID;
                default: t = THR_HIGH;
            endcase
        end
        return t;
    endfunction

    function automatic logic [2:0] pm_for(pd_class_e c);
        return {1'b0, c} + 3'd1;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/poe_seq_timer.sv
module poe_seq_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + CW'(1);
    end

    assign done = tick && (cnt == limit - CW'(1));
endmodule

// File: rtl/poe_ovld_timer.sv
module poe_ovld_timer #(
    parameter int LIMIT = 62,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic flag,
    input  logic tick,
    output logic trip
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !arm || !flag)
            cnt <= '0;
        else if (tick && cnt != LAST)
            cnt <= cnt + CW'(1);
    end

    assign trip = arm && flag && tick && (cnt == LAST);
endmodule

// File: rtl/poe_class_decode.sv
module poe_class_decode
    import poe_seq_pkg::*;
#(
    parameter int MEAS_W = 7,
    parameter int B1     = 11,
    parameter int B2     = 27,
    parameter int B3     = 43
) (
    input  logic [MEAS_W-1:0] meas,
    output pd_class_e         cls
);
    localparam int NB = 3;
    localparam int BND [NB] = '{B1, B2, B3};

    logic [NB-1:0] above;

    for (genvar i = 0; i < NB; i++) begin : g_cmp
        assign above[i] = (meas >= MEAS_W'(BND[i]));
    end

    always_comb begin
        if (above[2])      cls = PDC_3;
        else if (above[1]) cls = PDC_2;
        else if (above[0]) cls = PDC_1;
        else               cls = PDC_0;
    end
endmodule

// File: rtl/poe_seq_fsm.sv
module poe_seq_fsm
    import poe_seq_pkg::*;
#(
    parameter int CW        = 12,
    parameter int T_DET     = 290,
    parameter int T_CLS     = 37,
    parameter int T_PWAIT   = 108,
    parameter int T_BACKOFF = 3200,
    parameter int T_RESTART = 4000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    det_res,
    input  pd_class_e     cls_dec,
    input  logic          tmr_done,
    input  logic          ovld_trip,
    input  logic          disc_req,
    input  logic          shutdown,
    input  logic          midspan,
    input  logic          enforce_cls,
    input  logic          budget_over,
    output logic          tmr_clr,
    output logic [CW-1:0] tmr_limit,
    output logic          ovld_arm,
    output logic          port_en,
    output logic          det_en,
    output logic          cls_en,
    output logic [1:0]    ovld_thr,
    output logic [2:0]    pm_code,
    output logic [2:0]    fault
);
    localparam logic [CW-1:0] L_DET  = CW'(T_DET);
    localparam logic [CW-1:0] L_CLS  = CW'(T_CLS);
    localparam logic [CW-1:0] L_PW   = CW'(T_PWAIT);
    localparam logic [CW-1:0] L_BO   = CW'(T_BACKOFF);
    localparam logic [CW-1:0] L_RST  = CW'(T_RESTART);

    seq_state_e  st, nxt;
    fault_e      flt, flt_n;
    pd_profile_t prof, prof_n;

    always_comb begin
        nxt    = st;
        flt_n  = flt;
        prof_n = prof;
        if (shutdown) begin
            nxt = S_SHUT;
            if (st != S_SHUT) flt_n = FLT_SHUT;
        end else begin
            case (st)
                S_IDLE: nxt = S_DET;
                S_DET: if (tmr_done) begin
                    if (det_res == DET_VALID)
                        nxt = S_CLS;
                    else if (det_res != DET_OPEN && midspan)
                        nxt = S_BACKOFF;
                    else
                        nxt = S_IDLE;
                end
                S_CLS: if (tmr_done) begin
                    prof_n.cls = cls_dec;
                    prof_n.thr = pick_thr(cls_dec, enforce_cls);
                    nxt        = S_PWAIT;
                end
                S_PWAIT: if (tmr_done) begin
                    if (budget_over) begin
                        nxt   = S_FWAIT;
                        flt_n = FLT_BUDGET;
                    end else begin
                        nxt = S_ON;
                    end
                end
                S_ON: begin
                    if (ovld_trip) begin
                        nxt   = S_FWAIT;
                        flt_n = FLT_OVLD;
                    end else if (disc_req) begin
                        nxt   = S_IDLE;
                        flt_n = FLT_DISC;
                    end
                end
                S_FWAIT, S_BACKOFF: if (tmr_done) nxt = S_DET;
                S_SHUT: nxt = S_FWAIT;
                default: nxt = S_IDLE;
            endcase
        end
        if (nxt == S_DET && st != S_DET) flt_n = FLT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            flt  <= FLT_NONE;
            prof <= '{cls: PDC_0, thr: THR_HIGH};
        end else begin
            st   <= nxt;
            flt  <= flt_n;
            prof <= prof_n;
        end
    end

    always_comb begin
        case (st)
            S_DET:     tmr_limit = L_DET;
            S_CLS:     tmr_limit = L_CLS;
            S_PWAIT:   tmr_limit = L_PW;
            S_BACKOFF: tmr_limit = L_BO;
            S_FWAIT:   tmr_limit = L_RST;
            default:   tmr_limit = '1;
        endcase
    end

    assign tmr_clr  = (nxt != st);
    assign ovld_arm = (st == S_ON);
    assign port_en  = (st == S_ON);
    assign det_en   = (st == S_DET);
    assign cls_en   = (st == S_CLS);
    assign ovld_thr = prof.thr;
    assign pm_code  = (st == S_ON) ? pm_for(prof.cls) : 3'd0;
    assign fault    = flt;
endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq
    import poe_seq_pkg::*;
#(
    parameter int T_DET     = 290,
    parameter int T_CLS     = 37,
    parameter int T_PON     = 145,
    parameter int T_BACKOFF = 3200,
    parameter int T_RESTART = 4000,
    parameter int T_OVLD    = 62,
    parameter int MEAS_W    = 7,
    parameter int CLS_B1    = 11,
    parameter int CLS_B2    = 27,
    parameter int CLS_B3    = 43
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [1:0]        det_res,
    input  logic [MEAS_W-1:0] cls_meas,
    input  logic              ovld_flag,
    input  logic              disc_req,
    input  logic              shutdown,
    input  logic              midspan,
    input  logic              enforce_cls,
    input  logic              budget_over,
    output logic              port_en,
    output logic              det_en,
    output logic              cls_en,
    output logic [1:0]        ovld_thr,
    output logic [2:0]        pm_code,
    output logic [2:0]        fault
);
    localparam int T_PWAIT = T_PON - T_CLS;
    localparam int TMAX    = max2(max2(max2(T_DET, T_CLS), max2(T_PWAIT, T_BACKOFF)), T_RESTART);
    localparam int CW      = $clog2(TMAX + 1);

    logic          tmr_clr, tmr_done, ovld_arm, ovld_trip;
    logic [CW-1:0] tmr_limit;
    pd_class_e     cls_dec;

    poe_seq_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .clr(tmr_clr), .tick(tick),
        .limit(tmr_limit), .done(tmr_done)
    );

    poe_ovld_timer #(.LIMIT(T_OVLD)) u_ovld (
        .clk(clk), .rst(rst), .arm(ovld_arm), .flag(ovld_flag),
        .tick(tick), .trip(ovld_trip)
    );

    poe_class_decode #(.MEAS_W(MEAS_W), .B1(CLS_B1), .B2(CLS_B2), .B3(CLS_B3)) u_cls (
        .meas(cls_meas), .cls(cls_dec)
    );

    poe_seq_fsm #(
        .CW(CW), .T_DET(T_DET), .T_CLS(T_CLS), .T_PWAIT(T_PWAIT),
        .T_BACKOFF(T_BACKOFF), .T_RESTART(T_RESTART)
    ) u_fsm (
        .clk(clk), .rst(rst), .det_res(det_res), .cls_dec(cls_dec),
        .tmr_done(tmr_done), .ovld_trip(ovld_trip), .disc_req(disc_req),
        .shutdown(shutdown), .midspan(midspan), .enforce_cls(enforce_cls),
        .budget_over(budget_over), .tmr_clr(tmr_clr), .tmr_limit(tmr_limit),
        .ovld_arm(ovld_arm), .port_en(port_en), .det_en(det_en),
        .cls_en(cls_en), .ovld_thr(ovld_thr), .pm_code(pm_code), .fault(fault)
    );
endmodule

// File: rtl/poe_port_seq_chk.sv
module poe_port_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       ovld_flag,
    input logic       disc_req,
    input logic       shutdown,
    input logic       budget_over,
    input logic       port_en,
    input logic       det_en,
    input logic [2:0] fault
);
    // R9: shutdown removes power and blocks detection on the next edge
    a_r9_shut_forces_off: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> (!port_en && !det_en));

    // R10: disconnect while powered drops the port on the next edge
    a_r10_disc_drops_port: assert property (@(posedge clk) disable iff (rst)
        (disc_req && port_en && !shutdown) |=> !port_en);

    // R8: power is only applied when the budget was clear at the turn-on edge
    a_r8_budget_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(port_en) |-> !$past(budget_over));

    // R7: an overload fault needs the flag present at the turn-off edge
    a_r7_trip_needs_flag: assert property (@(posedge clk) disable iff (rst)
        ($fell(port_en) && fault == 3'd1) |-> $past(ovld_flag));

    // R11: a fault code only clears when detection begins
    a_r11_fault_clears_at_det: assert property (@(posedge clk) disable iff (rst)
        (!$stable(fault) && fault == 3'd0) |-> det_en);

    // R1: detection never runs while the port is powered
    a_r1_no_det_when_on: assert property (@(posedge clk) disable iff (rst)
        !(det_en && port_en));
endmodule

bind poe_port_seq poe_port_seq_chk u_chk (.*);

// File: tb/poe_port_seq_bench.sv
module poe_port_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P_DET = 5, P_CLS = 3, P_PON = 8, P_BO = 12, P_RST = 15, P_OVLD = 4;
    localparam int IMM = -1;
    localparam int ANY = -2;

    logic       clk = 1'b0;
    logic       rst, tick, ovld_flag, disc_req, shutdown, midspan, enforce_cls, budget_over;
    logic [1:0] det_res;
    logic [6:0] cls_meas;
    logic       port_en, det_en, cls_en;
    logic [1:0] ovld_thr;
    logic [2:0] pm_code, fault;
    logic [10:0] vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    poe_port_seq #(
        .T_DET(P_DET), .T_CLS(P_CLS), .T_PON(P_PON), .T_BACKOFF(P_BO),
        .T_RESTART(P_RST), .T_OVLD(P_OVLD)
    ) u_poe_port_seq (
        .clk(clk), .rst(rst), .tick(tick), .det_res(det_res), .cls_meas(cls_meas),
        .ovld_flag(ovld_flag), .disc_req(disc_req), .shutdown(shutdown),
        .midspan(midspan), .enforce_cls(enforce_cls), .budget_over(budget_over),
        .port_en(port_en), .det_en(det_en), .cls_en(cls_en), .ovld_thr(ovld_thr),
        .pm_code(pm_code), .fault(fault)
    );

    assign vec = {port_en, det_en, cls_en, ovld_thr, pm_code, fault};

    typedef struct {
        logic [10:0] v;
        int          ticks;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    int tot_ticks = 0;

    function automatic logic [10:0] mk(int p, int d, int c, int thr, int pm, int f);
        return {p[0], d[0], c[0], thr[1:0], pm[2:0], f[2:0]};
    endfunction

    task automatic push(logic [10:0] v, int t, string tag);
        exp_t e;
        e.v = v; e.ticks = t; e.tag = tag;
        q.push_back(e);
    endtask

    // timebase: one tick every third cycle
    initial begin
        int ph;
        tick = 1'b0;
        ph = 0;
        forever begin
            @(negedge clk);
            tick = (ph == 0);
            ph = (ph + 1) % 3;
        end
    end

    always @(posedge clk) if (tick) tot_ticks <= tot_ticks + 1;

    // monitor: every output change is compared against the scoreboard
    logic [10:0] prev_v;
    int          last_t;
    always @(negedge clk) begin
        exp_t e;
        int   d;
        bit   ok;
        if (rst) begin
            prev_v = vec;
            last_t = tot_ticks;
        end else if (vec !== prev_v) begin
            d = tot_ticks - last_t;
            last_t = tot_ticks;
            prev_v = vec;
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL unexpected change: got %h after %0d ticks, exp no change", vec, d);
            end else begin
                e = q.pop_front();
                ok = (vec === e.v);
                if (e.ticks == IMM) ok = ok && (d <= 1);
                else if (e.ticks != ANY) ok = ok && (d == e.ticks);
                if (!ok) begin
                    fails++;
                    $display("FAIL %s: got %h after %0d ticks, exp %h after %0d ticks",
                             e.tag, vec, d, e.v, e.ticks);
                end
            end
        end
    end

    task automatic drain();
        while (q.size() != 0) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (!tick);
    endtask

    task automatic pulse_disc();
        @(negedge clk); #1 disc_req = 1'b1;
        @(negedge clk); #1 disc_req = 1'b0;
    endtask

    task automatic check_int(int got, int exp, string tag);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d exp %0d", tag, got, exp);
        end
    endtask

    task automatic release_and_count(string tag);
        int n;
        wait_tick();
        @(negedge clk); #1 shutdown = 1'b0;
        push(mk(0,1,0,1,0,0), ANY, tag);
        n = 0;
        forever begin
            @(posedge clk);
            if (tick) n++;
            #1;
            if (det_en) break;
        end
        check_int(n, P_RST, tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout exp completion");
        summary();
    end

    initial begin
        int meas_l [7] = '{10, 11, 26, 27, 42, 43, 90};
        int pm_l   [7] = '{1, 2, 2, 3, 3, 4, 4};
        int thr_l  [7] = '{0, 1, 1, 2, 2, 0, 0};
        int pthr;

        rst = 1'b1; det_res = 2'b01; cls_meas = 7'd20; ovld_flag = 1'b0;
        disc_req = 1'b0; shutdown = 1'b0; midspan = 1'b1; enforce_cls = 1'b1;
        budget_over = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (vec !== 11'd0) begin
            fails++;
            $display("FAIL R12: got %h exp %h", vec, 11'd0);
        end
        push(mk(0,1,0,0,0,0), IMM, "R12 leave reset into detection");
        push(mk(0,0,1,0,0,0), P_DET, "R1 detection length");
        push(mk(0,0,0,1,0,0), P_CLS, "R2 classification length");
        push(mk(1,0,0,1,2,0), P_PON - P_CLS, "R3 turn-on delay, R4 class1");
        rst = 1'b0;
        drain();

        // R7: partial overload then full window
        push(mk(0,0,0,1,0,1), 2 + P_OVLD, "R7 overload count clears on drop");
        ovld_flag = 1'b1;
        wait_tick(); wait_tick();
        @(negedge clk); #1 ovld_flag = 1'b0;
        @(negedge clk); #1 ovld_flag = 1'b1;
        drain();
        ovld_flag = 1'b0;
        det_res = 2'b00;
        push(mk(0,1,0,1,0,0), P_RST, "R7 restart wait, R11 fault cleared");
        push(mk(0,0,0,1,0,0), P_DET, "R6 invalid ends detection");
        push(mk(0,1,0,1,0,0), P_BO, "R6 midspan backoff");
        drain();
        det_res = 2'b10;
        push(mk(0,0,0,1,0,0), P_DET, "R6 open ends detection");
        push(mk(0,1,0,1,0,0), IMM, "R6 open gets no backoff");
        drain();
        midspan = 1'b0; det_res = 2'b00;
        push(mk(0,0,0,1,0,0), P_DET, "R6 invalid strap clear");
        push(mk(0,1,0,1,0,0), IMM, "R6 no backoff with strap clear");
        drain();

        // R8: budget denial, class 2 under enforce
        det_res = 2'b01; cls_meas = 7'd30; budget_over = 1'b1;
        push(mk(0,0,1,1,0,0), P_DET, "R2 classification start");
        push(mk(0,0,0,2,0,0), P_CLS, "R5 class2 middle threshold");
        push(mk(0,0,0,2,0,4), P_PON - P_CLS, "R8 budget denial");
        push(mk(0,1,0,2,0,0), P_RST, "R8 restart after denial");
        drain();
        budget_over = 1'b0;

        // R10 and R5 with enforce clear
        enforce_cls = 1'b0; cls_meas = 7'd20;
        push(mk(0,0,1,2,0,0), P_DET, "R1 detection length");
        push(mk(0,0,0,0,0,0), P_CLS, "R5 enforce clear gives high threshold");
        push(mk(1,0,0,0,2,0), P_PON - P_CLS, "R3 turn-on delay");
        drain();
        push(mk(0,0,0,0,0,2), IMM, "R10 disconnect drops port");
        push(mk(0,1,0,0,0,0), IMM, "R10 redetect without wait");
        pulse_disc();
        drain();

        // R4 boundary sweep under enforce
        enforce_cls = 1'b1;
        pthr = 0;
        for (int i = 0; i < 7; i++) begin
            cls_meas = 7'(meas_l[i]);
            push(mk(0,0,1,pthr,0,0), P_DET, "R1 detection length");
            push(mk(0,0,0,thr_l[i],0,0), P_CLS, "R5 threshold by class");
            push(mk(1,0,0,thr_l[i],pm_l[i],0), P_PON - P_CLS, "R4 class boundary");
            drain();
            push(mk(0,0,0,thr_l[i],0,2), IMM, "R10 disconnect");
            push(mk(0,1,0,thr_l[i],0,0), IMM, "R11 fault cleared at detection");
            pulse_disc();
            drain();
            pthr = thr_l[i];
        end

        // R9: shutdown while powered, then during detection
        cls_meas = 7'd20;
        push(mk(0,0,1,0,0,0), P_DET, "R1 detection length");
        push(mk(0,0,0,1,0,0), P_CLS, "R5 class1 low threshold");
        push(mk(1,0,0,1,2,0), P_PON - P_CLS, "R3 turn-on delay");
        drain();
        push(mk(0,0,0,1,0,3), IMM, "R9 shutdown drops port");
        @(negedge clk); #1 shutdown = 1'b1;
        drain();
        repeat (20) wait_tick();
        release_and_count("R9 restart after shutdown");
        drain();
        push(mk(0,0,0,1,0,3), IMM, "R9 shutdown stops detection");
        @(negedge clk); #1 shutdown = 1'b1;
        drain();
        repeat (5) wait_tick();
        release_and_count("R9 restart after shutdown in detection");
        drain();

        // detection keeps cycling with strap clear, invalid result
        det_res = 2'b00;
        push(mk(0,0,0,1,0,0), P_DET, "R6 invalid strap clear");
        push(mk(0,1,0,1,0,0), IMM, "R6 no backoff");
        drain();
        repeat (4) @(negedge clk);
        check_int(q.size(), 0, "R11 scoreboard drained");
        summary();
    end
endmodule